// File: doc/BRIEF.md
# Delayed-LMS Error Computation Unit

This block forms the output of an eight-tap adaptive FIR filter and the error between a desired sample and that output, without any full multiplier. Each signed sample is cut into two-bit digits; every digit is decoded into a one-hot choice among the weight, twice the weight and three times the weight, and an AND/OR cell picks that multiple or zero. The partial products that share a digit position are summed over all taps first, one adder tree per position. A single shift-add stage then scales the position sums by powers of four, applies the correction for the negative-weighted sign bit, drops low-order bits and subtracts the result from the desired sample.

The unit sits in the filtering path of a delayed-LMS loop. Each cycle in which `in_valid` is high, a new tap vector, weight vector and desired sample are taken in. The matching output and error appear three clock cycles later with `out_valid` high, at a rate of one result per cycle. Weight adaptation lies outside this block.

Top module: `dlms_err_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `y` and `e` are 0, and they stay 0 in the first cycle after release.
- R2: `out_valid` is high exactly three rising edges after a rising edge at which `in_valid` was high, and low three edges after one at which it was low.
- R3: Tap i takes its sample from `samples[8i+7:8i]` and its weight from `weights[8i+7:8i]`. Both are two's complement. Digit k of a sample is bits [2k+1:2k], read unsigned (00→0, 01→w, 10→2w, 11→3w).
- R4: Let S_k be the sum over all taps of digit k times the weight, and C the sum of the weights of taps whose sample bit 7 is 1. The output is y = floor(T/2), with T = Σ_k floor(S_k·4^k/8) − C·32. With this, negative samples multiply correctly.
- R5: A product that is an exact multiple of 16 in every tap gives y equal to the exact dot product divided by 16. This includes the extreme case of all samples and weights at −128.
- R6: Within each position term, bits below weight 8 are discarded before the terms are added. For example, taps (x=1, w=7) and (x=4, w=3) give y=0 where an exact division of the dot product (19) by 16 would give 1.
- R7: `e` equals `desired − y` modulo 2^15, with `y`, `e` and `desired` all 15-bit two's complement, and no saturation.
- R8: Inputs presented on consecutive cycles each produce their own result on consecutive cycles, in order.
- R9: In a cycle where `out_valid` is low, `y` and `e` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the tap, weight and desired vectors this cycle |
| samples | input | 64 | Tap-delay line, tap i at bits [8i+7:8i] |
| weights | input | 64 | Weight vector, weight i at bits [8i+7:8i] |
| desired | input | 15 | Desired sample, same format as y |
| out_valid | output | 1 | y and e hold a new result |
| y | output | 15 | Truncated filter output |
| e | output | 15 | Error, desired minus y |

## Verification
The sign-bit correction and the low-bit truncation can act on the same result. The correction applies when a sample's top digit is negative, and the truncation when the lowest digit position leaves bits below weight 8. Vectors with negative samples whose low digits are non-zero, and random vectors, make both happen in one output. The error wrap and the full-scale output also coincide when the desired value is at its negative extreme while y is at its positive extreme. Each result is compared with a model built from the digit-sum formula of R4, and its arrival cycle is checked against R2.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

    // One-hot select produced from a two-bit sample digit.
    typedef struct packed {
        logic sel3;
        logic sel2;
        logic sel1;
    } digit_sel_t;

    function automatic digit_sel_t decode_digit(input logic [1:0] dg);
        digit_sel_t r;
        r.sel1 = ~dg[1] &  dg[0];
        r.sel2 =  dg[1] & ~dg[0];
        r.sel3 =  dg[1] &  dg[0];
        return r;
    endfunction

endpackage

// File: rtl/ecu_ppg.sv
module ecu_ppg
    import dlms_pkg::*;
#(
    parameter int L = 8,
    parameter int W = 8,
    localparam int NPOS = L / 2,
    localparam int PW = W + 2
) (
    input  logic [L-1:0]         x,
    input  logic [W-1:0]         w,
    output logic [NPOS*PW-1:0]   pp,
    output logic [PW-1:0]        sgn_pp
);

    logic signed [PW-1:0] mul1;
    logic signed [PW-1:0] mul2;
    logic signed [PW-1:0] mul3;

    always_comb begin
        mul1 = {{2{w[W-1]}}, w};
        mul2 = mul1 <<< 1;
        mul3 = mul1 + mul2;
    end

    for (genvar k = 0; k < NPOS; k++) begin : g_digit
        digit_sel_t sel;
        always_comb begin
            sel = decode_digit(x[2*k+1 -: 2]);
            pp[k*PW +: PW] = ({PW{sel.sel1}} & mul1)
                           | ({PW{sel.sel2}} & mul2)
                           | ({PW{sel.sel3}} & mul3);
        end
    end

    // Sign-correction partial product: the top digit was read unsigned.
    assign sgn_pp = x[L-1] ? mul1 : '0;

endmodule

// File: rtl/ecu_tree.sv
module ecu_tree #(
    parameter int N  = 8,
    parameter int PW = 10,
    localparam int SW = PW + $clog2(N)
) (
    input  logic [N*PW-1:0] terms,
    output logic [SW-1:0]   sum
);

    always_comb begin
        logic signed [SW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + {{(SW-PW){terms[i*PW+PW-1]}}, terms[i*PW +: PW]};
        end
        sum = acc;
    end

endmodule

// File: rtl/ecu_shift_add.sv
module ecu_shift_add #(
    parameter int NPOS    = 4,
    parameter int SW      = 13,
    parameter int FW      = 19,
    parameter int L       = 8,
    parameter int SHIFT_T = 3,
    parameter int GUARD   = 1,
    parameter int YW      = 15
) (
    input  logic [NPOS*SW-1:0] sums,
    input  logic [SW-1:0]      corr,
    input  logic [YW-1:0]      d,
    output logic [YW-1:0]      y,
    output logic [YW-1:0]      e
);

    logic signed [FW-1:0] acc;
    logic signed [FW-1:0] yfull;

    always_comb begin
        logic signed [FW-1:0] ext;
        acc = '0;
        for (int k = 0; k < NPOS; k++) begin
            ext = {{(FW-SW){sums[k*SW+SW-1]}}, sums[k*SW +: SW]};
            acc = acc + ((ext <<< (2*k)) >>> SHIFT_T);
        end
        ext = {{(FW-SW){corr[SW-1]}}, corr};
        acc = acc - ((ext <<< L) >>> SHIFT_T);
        yfull = acc >>> GUARD;
        y = yfull[YW-1:0];
        e = d - yfull[YW-1:0];
    end

endmodule

// File: rtl/dlms_err_unit.sv
module dlms_err_unit #(
    parameter int N     = 8,
    parameter int L     = 8,
    parameter int W     = 8,
    parameter int DROP  = 4,
    parameter int GUARD = 1,
    localparam int YW   = L + W + $clog2(N) - DROP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N*L-1:0]    samples,
    input  logic [N*W-1:0]    weights,
    input  logic [YW-1:0]     desired,
    output logic              out_valid,
    output logic [YW-1:0]     y,
    output logic [YW-1:0]     e
);

    localparam int NPOS    = L / 2;
    localparam int PW      = W + 2;
    localparam int SW      = PW + $clog2(N);
    localparam int FW      = L + W + $clog2(N);
    localparam int SHIFT_T = DROP - GUARD;

    // Stage 0: partial-product generators
    logic [NPOS*PW-1:0] pp_d [N];
    logic [N*PW-1:0]    sg_d;

    for (genvar i = 0; i < N; i++) begin : g_tap
        ecu_ppg #(.L(L), .W(W)) u_ppg (
            .x      (samples[i*L +: L]),
            .w      (weights[i*W +: W]),
            .pp     (pp_d[i]),
            .sgn_pp (sg_d[i*PW +: PW])
        );
    end

    // Stage 1 registers
    logic [NPOS*PW-1:0] pp_q [N];
    logic [N*PW-1:0]    sg_q;
    logic [YW-1:0]      d1_q;
    logic               v1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) pp_q[i] <= '0;
            sg_q <= '0;
            d1_q <= '0;
            v1_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                for (int i = 0; i < N; i++) pp_q[i] <= pp_d[i];
                sg_q <= sg_d;
                d1_q <= desired;
            end
        end
    end

    // Regroup by digit position across taps
    logic [N*PW-1:0] col [NPOS];

    always_comb begin
        for (int k = 0; k < NPOS; k++) begin
            for (int i = 0; i < N; i++) begin
                col[k][i*PW +: PW] = pp_q[i][k*PW +: PW];
            end
        end
    end

    logic [NPOS*SW-1:0] sum_d;
    logic [SW-1:0]      corr_d;

    for (genvar k = 0; k < NPOS; k++) begin : g_pos
        ecu_tree #(.N(N), .PW(PW)) u_tree (
            .terms (col[k]),
            .sum   (sum_d[k*SW +: SW])
        );
    end

    ecu_tree #(.N(N), .PW(PW)) u_corr_tree (
        .terms (sg_q),
        .sum   (corr_d)
    );

    // Stage 2 registers
    logic [NPOS*SW-1:0] sum_q;
    logic [SW-1:0]      corr_q;
    logic [YW-1:0]      d2_q;
    logic               v2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            corr_q <= '0;
            d2_q   <= '0;
            v2_q   <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                sum_q  <= sum_d;
                corr_q <= corr_d;
                d2_q   <= d1_q;
            end
        end
    end

    // Final shift-add and error
    logic [YW-1:0] y_d;
    logic [YW-1:0] e_d;

    ecu_shift_add #(
        .NPOS(NPOS), .SW(SW), .FW(FW), .L(L),
        .SHIFT_T(SHIFT_T), .GUARD(GUARD), .YW(YW)
    ) u_shift_add (
        .sums (sum_q),
        .corr (corr_q),
        .d    (d2_q),
        .y    (y_d),
        .e    (e_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y         <= '0;
            e         <= '0;
        end else begin
            out_valid <= v2_q;
            if (v2_q) begin
                y <= y_d;
                e <= e_d;
            end
        end
    end

endmodule

// File: rtl/dlms_err_unit_chk.sv
module dlms_err_unit_chk #(
    parameter int YW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [YW-1:0] desired,
    input logic          out_valid,
    input logic [YW-1:0] y,
    input logic [YW-1:0] e
);

    // R1: reset clears the result port
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && y == '0 && e == '0));

    // R2: fixed three-edge latency, both polarities
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    a_r2_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R7: error relates to the desired sample accepted three edges earlier
    a_r7_error_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (e == YW'($past(desired, 3) - y)));

    // R9: outputs hold when no new result arrives
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(y) && $stable(e)));

endmodule

bind dlms_err_unit dlms_err_unit_chk #(.YW(YW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .desired   (desired),
    .out_valid (out_valid),
    .y         (y),
    .e         (e)
);

// File: tb/test_dlms_err_unit.sv
`timescale 1ns/1ps
module test_dlms_err_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] samples = '0;
    logic [63:0] weights = '0;
    logic [14:0] desired = '0;
    logic        out_valid;
    logic [14:0] y;
    logic [14:0] e;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [14:0] ey;
        logic [14:0] ee;
        int          c;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [14:0] last_y = '0;
    logic [14:0] last_e = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dlms_err_unit i_dlms_err_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .samples(samples), .weights(weights), .desired(desired),
        .out_valid(out_valid), .y(y), .e(e)
    );

    // Digit-sum model from R3/R4/R6
    function automatic int model_y(logic [63:0] xs, logic [63:0] ws);
        int tot = 0;
        int c = 0;
        for (int k = 0; k < 4; k++) begin
            int s = 0;
            for (int i = 0; i < 8; i++) begin
                int wv = int'($signed(ws[i*8 +: 8]));
                s += int'(xs[i*8 + 2*k +: 2]) * wv;
            end
            tot += (s * (1 << (2*k))) >>> 3;
        end
        for (int i = 0; i < 8; i++) begin
            if (xs[i*8 + 7]) c += int'($signed(ws[i*8 +: 8]));
        end
        tot -= (c * 256) >>> 3;
        return tot >>> 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic send(input logic [63:0] xs, input logic [63:0] ws,
                        input logic [14:0] d, input string tag);
        exp_t it;
        int my;
        @(negedge clk);
        samples  = xs;
        weights  = ws;
        desired  = d;
        in_valid = 1'b1;
        my = model_y(xs, ws);
        it.ey = my[14:0];
        it.ee = d - my[14:0];
        it.c  = cyc + 3;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            samples  = 64'hA5A5_5A5A_F00F_0FF0;
            weights  = 64'h1234_5678_9ABC_DEF0;
            desired  = 15'h2AAA;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected result", 1, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check({it.tag, " y"}, int'($signed(y)), int'($signed(it.ey)));
                    check({it.tag, " e (R7)"}, int'($signed(e)), int'($signed(it.ee)));
                    check({it.tag, " arrival cycle (R2)"}, cyc, it.c);
                end
            end else begin
                // R9: no new result -> outputs hold
                check("R9 y hold", int'(y), int'(last_y));
                check("R9 e hold", int'(e), int'(last_e));
            end
            last_y = y;
            last_e = e;
        end
    end

    function automatic logic [63:0] rep8(input logic [7:0] b);
        return {8{b}};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 y in reset", int'(y), 0);
        check("R1 e in reset", int'(e), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after release", int'(out_valid), 0);
        check("R1 y after release", int'(y), 0);

        // R3: zero vectors and a single tap
        send(64'h0, 64'h0, 15'd0, "R3 zeros");
        send(64'h05, 64'h03, 15'd10, "R3 single tap");
        send(64'h0000_0000_0000_3000, 64'h0000_0000_0000_7F00, 15'd0, "R3 tap1 only");
        idle(4);

        // R6: truncation inside the position terms (model gives 0, exact 1)
        send(64'h0000_0000_0000_0401, 64'h0000_0000_0000_0307, 15'd5, "R6 truncation");
        idle(3);

        // R4/R5: sign correction, extreme negative inputs -> 8192
        send(rep8(8'h80), rep8(8'h80), 15'd0, "R5 full scale");
        send(rep8(8'hFF), rep8(8'h01), 15'd0, "R4 minus one samples");
        send(rep8(8'h80), rep8(8'h7F), 15'd100, "R4 negative extreme");
        idle(3);

        // R7: error wraps (8192 - (-16384) style extreme)
        send(rep8(8'h80), rep8(8'h80), 15'h4000, "R7 error wrap");
        idle(2);

        // R8: back-to-back random stream with mixed signs
        for (int n = 0; n < 200; n++) begin
            send({$urandom, $urandom}, {$urandom, $urandom}, 15'($urandom), "R8 stream");
        end
        idle(5);
        // R9: gaps between results
        for (int n = 0; n < 40; n++) begin
            send({$urandom, $urandom}, {$urandom, $urandom}, 15'($urandom), "R4 mixed");
            idle(n % 3);
        end
        idle(8);
        check("R8 all results delivered", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule